// File: doc/BRIEF.md
# SCSI DMA Channel Register Engine

This block is the bus-master DMA channel that sits next to a SCSI protocol core. It holds eight 32-bit channel registers behind a word-indexed register port. The command register starts, idles or aborts the channel. A start copies the start count, start address and start descriptor-list address into their working copies. The working count and working address then track the data as chunks move.

The SCSI core asks for chunks through a request that carries a length and a direction. In the same cycle the engine either grants the request or refuses it. A grant returns the length clipped to the remaining count and the address to use. The counters step at the next clock edge. A command-complete input forces the remaining count to zero and sets the done flag. A select input chooses whether the error, abort and done flags clear on a status write or on a status read.

A four-state machine drives the channel control outputs:
- CH_OFF: DMA disabled.
- CH_RUN: DMA enabled.
- CH_CANCEL_OFF and CH_CANCEL_RUN: one-cycle cancel states that return to CH_OFF and CH_RUN respectively.

A start command moves the machine to CH_RUN and an idle command moves it to CH_OFF. An abort moves it to the cancel state that matches its current enable. A blast command, or no command, keeps the current enable. Any command written during a cancel state is decoded as if the machine were already in that state's return state.

Top module: `scsi_dma_chan`

## Requirements
- R1: After reset:
  - the command, start count, start address, start descriptor-list address and status registers read 0;
  - the working count reads 0;
  - the working address reads 0xFFFFFFFF;
  - the working descriptor-list address reads 0xFFFFFFFD;
  - dma_en and cancel_pulse are low.
- R2: Register indices are 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start descriptor-list address, 7 working descriptor-list address. Writes to indices 0, 1, 2 and 6 store the data, which reads back unchanged.
- R3: Register writes to indices 3, 4 and 7 have no effect on those registers.
- R4: Command bits [1:0] select the operation: 3 start, 0 idle, 1 blast, 2 abort.
  - A start write raises dma_en from the next cycle.
  - An idle write lowers dma_en from the next cycle.
  - A blast write leaves dma_en unchanged.
- R5: An abort write (command bits [1:0] = 2) raises cancel_pulse for exactly the next cycle and leaves dma_en unchanged.
- R6: A start write copies the start count, start address and start descriptor-list address into their working registers. It also clears status bits 5:0. Status bit 0 is power-down, 1 error, 2 abort, 3 done, 4 SCSI interrupt, 5 count blast.
- R7: With stat_clr_on_rd low, a write to the status register clears each of bits 1, 2 and 3 for which the written data holds a 1. All other status bits are unchanged.
- R8: With stat_clr_on_rd high, a status read returns the current bits and then clears bits 1, 2 and 3. A status write has no effect.
- R9: A status read shows bit 4 set whenever scsi_irq is high, in the same cycle.
- R10: A chunk request whose direction matches command bit 7 (1 = device to memory) is granted in the same cycle. gnt_len is the smaller of chunk_len and the working count, and gnt_addr is the working address. After the grant, the working count drops by gnt_len and the working address rises by gnt_len.
- R11: A chunk request whose direction does not match command bit 7 is refused: chunk_refused is high, chunk_gnt is low, and the working count and working address are unchanged.
- R12: A cmd_done pulse sets the working count to 0 and sets status bit 3. Both take priority over a start or a grant in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous hard reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives clear-on-read) |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_idx |
| stat_clr_on_rd | input | 1 | 1: status flags clear on read; 0: they clear on write |
| scsi_irq | input | 1 | Interrupt level from the SCSI core |
| cmd_done | input | 1 | Command-complete pulse from the SCSI core |
| chunk_req | input | 1 | Chunk transfer request |
| chunk_dir | input | 1 | Requested direction, 1 = device to memory |
| chunk_len | input | 32 | Requested chunk length in bytes |
| chunk_gnt | output | 1 | Chunk granted this cycle |
| chunk_refused | output | 1 | Chunk refused for wrong direction |
| gnt_len | output | 32 | Granted (clipped) length |
| gnt_addr | output | 32 | Address for the granted chunk |
| dma_en | output | 1 | DMA enable level toward the SCSI core |
| cancel_pulse | output | 1 | One-cycle cancel toward the SCSI core |

## Verification
The bench targets the chunk that asks for more than the remaining count. A design that fails to clip it would grant the full length, and the count would wrap below zero. It sends a request in the wrong direction; a design that ignores command bit 7 would move the counters. It runs both status-clear modes, where a swapped select would clear done on the wrong access or let a write through. It also issues a start in the same cycle as a command completion: the count must end at zero with done set. A wrong priority would leave the reloaded count, or a cleared done flag.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;

    localparam int unsigned IDX_W = 3;

    localparam logic [IDX_W-1:0] IX_CMD  = 3'd0;
    localparam logic [IDX_W-1:0] IX_SCNT = 3'd1;
    localparam logic [IDX_W-1:0] IX_SADR = 3'd2;
    localparam logic [IDX_W-1:0] IX_WCNT = 3'd3;
    localparam logic [IDX_W-1:0] IX_WADR = 3'd4;
    localparam logic [IDX_W-1:0] IX_STAT = 3'd5;
    localparam logic [IDX_W-1:0] IX_SDSC = 3'd6;
    localparam logic [IDX_W-1:0] IX_WDSC = 3'd7;

    localparam int unsigned CMD_DIR_BIT = 7;

    localparam int unsigned ST_W     = 6;
    localparam int unsigned ST_PWDN  = 0;
    localparam int unsigned ST_ERR   = 1;
    localparam int unsigned ST_ABT   = 2;
    localparam int unsigned ST_DONE  = 3;
    localparam int unsigned ST_SCSI  = 4;
    localparam int unsigned ST_BLAST = 5;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_BLAST = 2'd1,
        OP_ABORT = 2'd2,
        OP_START = 2'd3
    } dma_op_e;

    typedef enum logic [1:0] {
        CH_OFF        = 2'd0,
        CH_RUN        = 2'd1,
        CH_CANCEL_OFF = 2'd2,
        CH_CANCEL_RUN = 2'd3
    } chan_state_e;

endpackage

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import scsi_dma_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_wr,
    input  dma_op_e cmd_op,
    output logic    dma_en,
    output logic    cancel_pulse,
    output logic    load_start
);

    chan_state_e state, nxt;

    assign load_start = cmd_wr && (cmd_op == OP_START);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CH_OFF, CH_CANCEL_OFF: begin
                nxt = CH_OFF;
                if (cmd_wr) begin
                    unique case (cmd_op)
                        OP_START: nxt = CH_RUN;
                        OP_ABORT: nxt = CH_CANCEL_OFF;
                        default:  nxt = CH_OFF;
                    endcase
                end
            end
            CH_RUN, CH_CANCEL_RUN: begin
                nxt = CH_RUN;
                if (cmd_wr) begin
                    unique case (cmd_op)
                        OP_IDLE:  nxt = CH_OFF;
                        OP_ABORT: nxt = CH_CANCEL_RUN;
                        default:  nxt = CH_RUN;
                    endcase
                end
            end
        endcase
    end

    always_comb begin
        dma_en       = 1'b0;
        cancel_pulse = 1'b0;
        unique case (state)
            CH_OFF:        begin dma_en = 1'b0; cancel_pulse = 1'b0; end
            CH_RUN:        begin dma_en = 1'b1; cancel_pulse = 1'b0; end
            CH_CANCEL_OFF: begin dma_en = 1'b0; cancel_pulse = 1'b1; end
            CH_CANCEL_RUN: begin dma_en = 1'b1; cancel_pulse = 1'b1; end
        endcase
    end

    // R4: start enables, idle disables
    p_start_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_op == OP_START) |=> dma_en);
    p_idle_dis_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_op == OP_IDLE) |=> !dma_en);
    // R5: abort gives a pulse and keeps the enable level
    p_abort_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_op == OP_ABORT) |=> cancel_pulse);
    p_abort_keep_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_op == OP_ABORT) |=> (dma_en == $past(dma_en)));
    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_pulse && !(cmd_wr && cmd_op == OP_ABORT)) |=> !cancel_pulse);

endmodule

// File: rtl/dma_status_bits.sv
module dma_status_bits
    import scsi_dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_start,
    input  logic            cmd_done,
    input  logic            clr_on_rd,
    input  logic            wr_stat,
    input  logic            rd_stat,
    input  logic [ST_W-1:0] wdata,
    input  logic            scsi_irq,
    output logic [ST_W-1:0] stat_view
);

    localparam logic [ST_W-1:0] CLR_MASK =
        ST_W'((1 << ST_ERR) | (1 << ST_ABT) | (1 << ST_DONE));

    logic [ST_W-1:0] stat_q, stat_d;

    always_comb begin
        stat_d = stat_q;
        if (load_start)              stat_d = '0;
        if (wr_stat && !clr_on_rd)   stat_d = stat_d & ~(wdata & CLR_MASK);
        if (rd_stat && clr_on_rd)    stat_d = stat_d & ~CLR_MASK;
        if (cmd_done)                stat_d[ST_DONE] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_view = stat_q | (ST_W'(scsi_irq) << ST_SCSI);

    // R12: completion sets done
    p_done_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> stat_view[ST_DONE]);
    // R8: read clears the three flags; write is ignored
    p_rd_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && clr_on_rd && !cmd_done) |=> ((stat_q & CLR_MASK) == '0));
    p_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && clr_on_rd && !rd_stat && !load_start && !cmd_done) |=> $stable(stat_q));
    // R6: start clears all stored status
    p_start_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_start && !cmd_done) |=> (stat_q == '0));

endmodule

// File: rtl/dma_work_ctr.sv
module dma_work_ctr #(
    parameter int unsigned DW = 32,
    parameter logic [DW-1:0] WADR_RST = '1,
    parameter logic [DW-1:0] WDSC_RST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_start,
    input  logic          cmd_done,
    input  logic [DW-1:0] scnt,
    input  logic [DW-1:0] sadr,
    input  logic [DW-1:0] sdsc,
    input  logic          dir_cfg,
    input  logic          chunk_req,
    input  logic          chunk_dir,
    input  logic [DW-1:0] chunk_len,
    output logic          chunk_gnt,
    output logic          chunk_refused,
    output logic [DW-1:0] gnt_len,
    output logic [DW-1:0] gnt_addr,
    output logic [DW-1:0] wcnt,
    output logic [DW-1:0] wadr,
    output logic [DW-1:0] wdsc
);

    logic          dir_ok;
    logic [DW-1:0] fit_len;

    assign dir_ok        = (chunk_dir == dir_cfg);
    assign chunk_gnt     = chunk_req && dir_ok;
    assign chunk_refused = chunk_req && !dir_ok;
    assign fit_len       = (chunk_len < wcnt) ? chunk_len : wcnt;
    assign gnt_len       = chunk_gnt ? fit_len : '0;
    assign gnt_addr      = wadr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
            wadr <= WADR_RST;
            wdsc <= WDSC_RST;
        end else begin
            if (cmd_done)       wcnt <= '0;
            else if (load_start) wcnt <= scnt;
            else if (chunk_gnt) wcnt <= wcnt - fit_len;

            if (load_start)     wadr <= sadr;
            else if (chunk_gnt) wadr <= wadr + fit_len;

            if (load_start)     wdsc <= sdsc;
        end
    end

    // R10: grant clipped, counters step by the granted length
    p_gnt_clip_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_gnt |-> (gnt_len <= wcnt && gnt_len <= chunk_len));
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_gnt && !load_start && !cmd_done) |=> (wcnt == $past(wcnt) - $past(gnt_len)));
    p_adr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_gnt && !load_start) |=> (wadr == $past(wadr) + $past(gnt_len)));
    // R11: refusal leaves counters alone
    p_refuse_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (chunk_refused && !load_start && !cmd_done) |=> ($stable(wcnt) && $stable(wadr)));
    // R12: completion zeroes the count
    p_done_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> (wcnt == '0));

endmodule

// File: rtl/scsi_dma_chan.sv
module scsi_dma_chan
    import scsi_dma_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter logic [DW-1:0] WADR_RST = 32'hFFFF_FFFF,
    parameter logic [DW-1:0] WDSC_RST = 32'hFFFF_FFFD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             stat_clr_on_rd,
    input  logic             scsi_irq,
    input  logic             cmd_done,
    input  logic             chunk_req,
    input  logic             chunk_dir,
    input  logic [DW-1:0]    chunk_len,
    output logic             chunk_gnt,
    output logic             chunk_refused,
    output logic [DW-1:0]    gnt_len,
    output logic [DW-1:0]    gnt_addr,
    output logic             dma_en,
    output logic             cancel_pulse
);

    logic [DW-1:0]   cmd_q, scnt_q, sadr_q, sdsc_q;
    logic [DW-1:0]   wcnt, wadr, wdsc;
    logic [ST_W-1:0] stat_view;
    logic            cmd_wr, load_start;
    dma_op_e         cmd_op;

    assign cmd_wr = reg_wr && (reg_idx == IX_CMD);
    assign cmd_op = dma_op_e'(reg_wdata[1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            scnt_q <= '0;
            sadr_q <= '0;
            sdsc_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_idx)
                IX_CMD:  cmd_q  <= reg_wdata;
                IX_SCNT: scnt_q <= reg_wdata;
                IX_SADR: sadr_q <= reg_wdata;
                IX_SDSC: sdsc_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    dma_chan_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .cmd_op       (cmd_op),
        .dma_en       (dma_en),
        .cancel_pulse (cancel_pulse),
        .load_start   (load_start)
    );

    dma_status_bits u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_start (load_start),
        .cmd_done   (cmd_done),
        .clr_on_rd  (stat_clr_on_rd),
        .wr_stat    (reg_wr && reg_idx == IX_STAT),
        .rd_stat    (reg_rd && reg_idx == IX_STAT),
        .wdata      (reg_wdata[ST_W-1:0]),
        .scsi_irq   (scsi_irq),
        .stat_view  (stat_view)
    );

    dma_work_ctr #(
        .DW       (DW),
        .WADR_RST (WADR_RST),
        .WDSC_RST (WDSC_RST)
    ) u_ctr (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_start    (load_start),
        .cmd_done      (cmd_done),
        .scnt          (scnt_q),
        .sadr          (sadr_q),
        .sdsc          (sdsc_q),
        .dir_cfg       (cmd_q[CMD_DIR_BIT]),
        .chunk_req     (chunk_req),
        .chunk_dir     (chunk_dir),
        .chunk_len     (chunk_len),
        .chunk_gnt     (chunk_gnt),
        .chunk_refused (chunk_refused),
        .gnt_len       (gnt_len),
        .gnt_addr      (gnt_addr),
        .wcnt          (wcnt),
        .wadr          (wadr),
        .wdsc          (wdsc)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_idx)
            IX_CMD:  reg_rdata = cmd_q;
            IX_SCNT: reg_rdata = scnt_q;
            IX_SADR: reg_rdata = sadr_q;
            IX_WCNT: reg_rdata = wcnt;
            IX_WADR: reg_rdata = wadr;
            IX_STAT: reg_rdata = DW'(stat_view);
            IX_SDSC: reg_rdata = sdsc_q;
            IX_WDSC: reg_rdata = wdsc;
        endcase
    end

    // R3: working registers do not follow a register write
    p_wreg_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_idx == IX_WDSC) |=> $stable(wdsc));
    // R11: grant and refusal never together
    p_gnt_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(chunk_gnt && chunk_refused));

endmodule

// File: tb/scsi_dma_chan_test.sv
module scsi_dma_chan_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        stat_clr_on_rd = 1'b0, scsi_irq = 1'b0, cmd_done = 1'b0;
    logic        chunk_req = 1'b0, chunk_dir = 1'b0;
    logic [31:0] chunk_len = '0;
    logic        chunk_gnt, chunk_refused, dma_en, cancel_pulse;
    logic [31:0] gnt_len, gnt_addr;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    scsi_dma_chan uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stat_clr_on_rd(stat_clr_on_rd), .scsi_irq(scsi_irq), .cmd_done(cmd_done),
        .chunk_req(chunk_req), .chunk_dir(chunk_dir), .chunk_len(chunk_len),
        .chunk_gnt(chunk_gnt), .chunk_refused(chunk_refused),
        .gnt_len(gnt_len), .gnt_addr(gnt_addr),
        .dma_en(dma_en), .cancel_pulse(cancel_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = idx;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chunk(input logic dir, input logic [31:0] len,
                         output logic g, output logic r,
                         output logic [31:0] gl, output logic [31:0] ga);
        @(negedge clk);
        chunk_req = 1'b1; chunk_dir = dir; chunk_len = len;
        #1 g = chunk_gnt; r = chunk_refused; gl = gnt_len; ga = gnt_addr;
        @(negedge clk);
        chunk_req = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 dma_en", {31'b0, dma_en}, 0);
        check("R1 cancel", {31'b0, cancel_pulse}, 0);
        rd(0, v); check("R1 cmd", v, 0);
        rd(3, v); check("R1 wcnt", v, 0);
        rd(4, v); check("R1 wadr", v, 32'hFFFF_FFFF);
        rd(5, v); check("R1 stat", v, 0);
        rd(7, v); check("R1 wdsc", v, 32'hFFFF_FFFD);
    endtask

    task automatic t_store_and_ignore();
        logic [31:0] v;
        wr(1, 32'h100); wr(2, 32'h1000); wr(6, 32'hABC0);
        rd(1, v); check("R2 scnt", v, 32'h100);
        rd(2, v); check("R2 sadr", v, 32'h1000);
        rd(6, v); check("R2 sdsc", v, 32'hABC0);
        wr(3, 32'h1234); wr(4, 32'h5678); wr(7, 32'h9ABC);
        rd(3, v); check("R3 wcnt", v, 0);
        rd(4, v); check("R3 wadr", v, 32'hFFFF_FFFF);
        rd(7, v); check("R3 wdsc", v, 32'hFFFF_FFFD);
    endtask

    task automatic t_start_and_chunks();
        logic [31:0] v, gl, ga;
        logic g, r;
        wr(0, 32'h03);
        check("R4 start en", {31'b0, dma_en}, 1);
        rd(0, v); check("R2 cmd", v, 32'h03);
        rd(3, v); check("R6 wcnt", v, 32'h100);
        rd(4, v); check("R6 wadr", v, 32'h1000);
        rd(7, v); check("R6 wdsc", v, 32'hABC0);
        chunk(1'b0, 32'h40, g, r, gl, ga);
        check("R10 gnt", {31'b0, g}, 1);
        check("R10 len", gl, 32'h40);
        check("R10 addr", ga, 32'h1000);
        rd(3, v); check("R10 wcnt step", v, 32'hC0);
        rd(4, v); check("R10 wadr step", v, 32'h1040);
        chunk(1'b1, 32'h10, g, r, gl, ga);
        check("R11 refused", {31'b0, r}, 1);
        check("R11 no gnt", {31'b0, g}, 0);
        rd(3, v); check("R11 wcnt hold", v, 32'hC0);
        rd(4, v); check("R11 wadr hold", v, 32'h1040);
        chunk(1'b0, 32'h200, g, r, gl, ga);
        check("R10 clip len", gl, 32'hC0);
        check("R10 clip addr", ga, 32'h1040);
        rd(3, v); check("R10 wcnt zero", v, 0);
        rd(4, v); check("R10 wadr end", v, 32'h1100);
    endtask

    task automatic t_ops();
        wr(0, 32'h01);
        check("R4 blast keeps en", {31'b0, dma_en}, 1);
        wr(0, 32'h02);
        check("R5 pulse run", {31'b0, cancel_pulse}, 1);
        check("R5 en kept run", {31'b0, dma_en}, 1);
        @(negedge clk);
        check("R5 pulse ends", {31'b0, cancel_pulse}, 0);
        wr(0, 32'h00);
        check("R4 idle", {31'b0, dma_en}, 0);
        wr(0, 32'h02);
        check("R5 pulse off", {31'b0, cancel_pulse}, 1);
        check("R5 en kept off", {31'b0, dma_en}, 0);
        @(negedge clk);
        check("R5 pulse ends off", {31'b0, cancel_pulse}, 0);
    endtask

    task automatic t_done_and_status();
        logic [31:0] v, gl, ga;
        logic g, r;
        wr(1, 32'h50);
        wr(0, 32'h83);
        rd(3, v); check("R6 reload", v, 32'h50);
        chunk(1'b1, 32'h10, g, r, gl, ga);
        check("R10 dir1 gnt", {31'b0, g}, 1);
        done_pulse();
        rd(3, v); check("R12 wcnt", v, 0);
        rd(5, v); check("R12 done", v, 32'h08);
        wr(5, 32'h07);
        rd(5, v); check("R7 no clear", v, 32'h08);
        wr(5, 32'h08);
        rd(5, v); check("R7 clear", v, 0);
        scsi_irq = 1'b1;
        rd(5, v); check("R9 irq on", v, 32'h10);
        scsi_irq = 1'b0;
        rd(5, v); check("R9 irq off", v, 0);
        done_pulse();
        wr(0, 32'h83);
        rd(5, v); check("R6 stat clear", v, 0);
        stat_clr_on_rd = 1'b1;
        done_pulse();
        wr(5, 32'hFF);
        rd(5, v); check("R8 read value", v, 32'h08);
        rd(5, v); check("R8 cleared", v, 0);
        stat_clr_on_rd = 1'b0;
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(1, 32'h77);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = 3'd0; reg_wdata = 32'h03; cmd_done = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; cmd_done = 1'b0;
        rd(3, v); check("R12 prio wcnt", v, 0);
        rd(5, v); check("R12 prio done", v, 32'h08);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_store_and_ignore();
        t_start_and_chunks();
        t_ops();
        t_done_and_status();
        t_priority();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule